// File: doc/BRIEF.md
# Conversion Result Buffer with Read Protection

This block receives finished analog-to-digital conversion results and parks them in a bank of result registers, where software or another master later reads them. Each input channel owns a pointer into the bank and a stage count. A channel can therefore own one register of its own, or a ring of consecutive registers that acts as a first-in first-out store. The ring lets a fast converter run ahead of a slow reader without overwriting results.

Before a result is stored it can be narrowed to 10 or 8 bits, or summed over several consecutive samples. When read protection is on, a register still holding an unread value refuses the next result. The refused result is dropped and a sticky lost-data flag is raised. Each stored result produces a one-cycle event pulse.

Top module: `result_buffer`

## Requirements
- R1: After reset, `rd_vld`, `res_evt` and `lost` are 0 and every register is marked empty. Channel i targets register (2*i) mod 16 as a single stage.
- R2: A read strobe with index k returns register k on `rd_data` on the next cycle. `rd_vld` is 1 if the register held an unread value and 0 otherwise. The strobe marks the register empty, and its data stays readable.
- R3: With `wfr_en` = 0, a new result overwrites an unread register, and `lost` stays 0.
- R4: With `wfr_en` = 1, a result aimed at an unread register is dropped. The register keeps its old value, no event fires, and `lost` becomes 1 and stays 1.
- R5: A configuration write (`cfg_we`) clears `lost`. It loads the addressed channel's base register and stage count, and restarts that channel's ring position and partial sum.
- R6: A channel with base b and `cfg_depth` d writes registers b, b+1, …, b+d (mod 16) in turn, then wraps back to b. A dropped result does not advance the position.
- R7: `res_evt` is high for exactly the one cycle that follows the clock edge on which a result is stored.
- R8: With `acc_sel` = n, the channel adds n+1 consecutive results and stores only the sum (up to 14 bits). Only the last of those results raises an event.
- R9: `width_sel` selects the stored width: 0 keeps all 12 bits, 1 keeps bits 11:2 right-aligned, and 2 or 3 keeps bits 11:4 right-aligned. Narrowing is applied to each sample before summation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_vld | input | 1 | A conversion result is present this cycle |
| conv_ch | input | 3 | Channel of the result |
| conv_data | input | 12 | Raw conversion value |
| rd_en | input | 1 | Read strobe |
| rd_idx | input | 4 | Register index to read |
| cfg_we | input | 1 | Configuration write for one channel; clears lost |
| cfg_ch | input | 3 | Channel being configured |
| cfg_ptr | input | 4 | Base register for that channel |
| cfg_depth | input | 4 | Stage count minus one for that channel |
| wfr_en | input | 1 | Enable read protection |
| acc_sel | input | 2 | Samples summed per stored result, minus one |
| width_sel | input | 2 | Stored width selection |
| rd_data | output | 14 | Data of the register read |
| rd_vld | output | 1 | The register read held an unread value |
| res_evt | output | 1 | A result was stored |
| lost | output | 1 | Sticky flag: a result was dropped |

## Verification
The bench drives a full ring until a fourth result hits a register that has not been read. It then checks that the result is dropped and the ring position holds, and that the next accepted result lands at the base again. A design that advanced on a drop would put that result one register too far. A ring placed at base 15 checks that addresses wrap to register 0, which an unwrapped adder would miss. With summation, the bench checks that intermediate samples raise no event and that a sum of four full-scale values needs the full 14 bits. It also checks that narrowing takes the upper bits rather than the lower bits, and that overwriting without protection never raises the lost flag.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int CONV_W = 12;

  typedef enum logic [1:0] {
    WID_12  = 2'd0,
    WID_10  = 2'd1,
    WID_8   = 2'd2,
    WID_8B  = 2'd3
  } width_e;

  // Keep the upper bits of a conversion, right-aligned.
  function automatic logic [CONV_W-1:0] narrow(input logic [CONV_W-1:0] d,
                                               input logic [1:0] sel);
    case (width_e'(sel))
      WID_12:  narrow = d;
      WID_10:  narrow = d >> 2;
      default: narrow = d >> 4;
    endcase
  endfunction
endpackage

// File: rtl/rb_chan_ctrl.sv
module rb_chan_ctrl #(
  parameter int RW = 4,
  parameter int ACW = 2,
  parameter int SUMW = 14,
  parameter logic [RW-1:0] RST_BASE = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_hit,
  input  logic [RW-1:0]   cfg_ptr,
  input  logic [RW-1:0]   cfg_depth,
  input  logic            smp_hit,
  input  logic [SUMW-1:0] smp,
  input  logic [ACW-1:0]  acc_sel,
  input  logic            accept,
  output logic            last,
  output logic [SUMW-1:0] sum,
  output logic [RW-1:0]   tgt
);
  logic [RW-1:0]   base, depth, off;
  logic [ACW-1:0]  cnt;
  logic [SUMW-1:0] acc;

  assign last = (cnt == acc_sel);
  assign sum  = acc + smp;
  assign tgt  = base + off;

  always_ff @(posedge clk) begin
    if (rst) begin
      base  <= RST_BASE;
      depth <= '0;
      off   <= '0;
      cnt   <= '0;
      acc   <= '0;
    end else if (cfg_hit) begin
      base  <= cfg_ptr;
      depth <= cfg_depth;
      off   <= '0;
      cnt   <= '0;
      acc   <= '0;
    end else if (smp_hit) begin
      if (last) begin
        cnt <= '0;
        acc <= '0;
        if (accept) off <= (off == depth) ? '0 : off + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
        acc <= sum;
      end
    end
  end
endmodule

// File: rtl/rb_bank.sv
module rb_bank #(
  parameter int NUM_REG = 16,
  parameter int RW = 4,
  parameter int DW = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [RW-1:0]      waddr,
  input  logic [DW-1:0]      wdata,
  input  logic               re,
  input  logic [RW-1:0]      raddr,
  output logic [DW-1:0]      rdata,
  output logic               rvld,
  output logic [NUM_REG-1:0] full
);
  logic [DW-1:0] mem [NUM_REG];

  // Storage without reset so it can map to block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) rvld <= 1'b0;
    else     rvld <= re & full[raddr];
  end

  for (genvar k = 0; k < NUM_REG; k++) begin : g_full
    always_ff @(posedge clk) begin
      if (rst)                               full[k] <= 1'b0;
      else if (we && waddr == RW'(k))        full[k] <= 1'b1;
      else if (re && raddr == RW'(k))        full[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/result_buffer.sv
module result_buffer #(
  parameter int NUM_CH = 8,
  parameter int NUM_REG = 16,
  parameter int MAX_ACC = 4,
  localparam int CHW = $clog2(NUM_CH),
  localparam int RW = $clog2(NUM_REG),
  localparam int ACW = $clog2(MAX_ACC),
  localparam int SUMW = rb_pkg::CONV_W + ACW
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      conv_vld,
  input  logic [CHW-1:0]            conv_ch,
  input  logic [rb_pkg::CONV_W-1:0] conv_data,
  input  logic                      rd_en,
  input  logic [RW-1:0]             rd_idx,
  input  logic                      cfg_we,
  input  logic [CHW-1:0]            cfg_ch,
  input  logic [RW-1:0]             cfg_ptr,
  input  logic [RW-1:0]             cfg_depth,
  input  logic                      wfr_en,
  input  logic [ACW-1:0]            acc_sel,
  input  logic [1:0]                width_sel,
  output logic [SUMW-1:0]           rd_data,
  output logic                      rd_vld,
  output logic                      res_evt,
  output logic                      lost
);
  logic            ch_last [NUM_CH];
  logic [SUMW-1:0] ch_sum  [NUM_CH];
  logic [RW-1:0]   ch_tgt  [NUM_CH];
  logic [NUM_REG-1:0] full;
  logic [SUMW-1:0] smp;
  logic commit, ok, wr;

  assign smp    = SUMW'(rb_pkg::narrow(conv_data, width_sel));
  assign commit = conv_vld & ch_last[conv_ch];
  assign ok     = ~(wfr_en & full[ch_tgt[conv_ch]]);
  assign wr     = commit & ok;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    rb_chan_ctrl #(
      .RW(RW), .ACW(ACW), .SUMW(SUMW),
      .RST_BASE(RW'((2 * i) % NUM_REG))
    ) i_ctrl (
      .clk      (clk),
      .rst      (rst),
      .cfg_hit  (cfg_we && cfg_ch == CHW'(i)),
      .cfg_ptr  (cfg_ptr),
      .cfg_depth(cfg_depth),
      .smp_hit  (conv_vld && conv_ch == CHW'(i)),
      .smp      (smp),
      .acc_sel  (acc_sel),
      .accept   (ok),
      .last     (ch_last[i]),
      .sum      (ch_sum[i]),
      .tgt      (ch_tgt[i])
    );
  end

  rb_bank #(.NUM_REG(NUM_REG), .RW(RW), .DW(SUMW)) i_bank (
    .clk  (clk),
    .rst  (rst),
    .we   (wr),
    .waddr(ch_tgt[conv_ch]),
    .wdata(ch_sum[conv_ch]),
    .re   (rd_en),
    .raddr(rd_idx),
    .rdata(rd_data),
    .rvld (rd_vld),
    .full (full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_evt <= 1'b0;
      lost    <= 1'b0;
    end else begin
      res_evt <= wr;
      if (commit && !ok) lost <= 1'b1;
      else if (cfg_we)   lost <= 1'b0;
    end
  end
endmodule

// File: rtl/rb_chk.sv
module rb_chk (
  input logic clk,
  input logic rst,
  input logic conv_vld,
  input logic rd_en,
  input logic cfg_we,
  input logic wfr_en,
  input logic res_evt,
  input logic rd_vld,
  input logic lost
);
  // R7
  evt_src_chk: assert property (@(posedge clk) disable iff (rst)
    res_evt |-> $past(conv_vld));
  // R2
  rdvld_src_chk: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> $past(rd_en));
  // R4
  lost_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lost && !cfg_we) |=> lost);
  // R3
  lost_needs_wfr_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lost) |-> $past(wfr_en));
  // R4
  lost_no_evt_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lost) |-> !res_evt);
  // R5
  lost_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !conv_vld) |=> !lost);
endmodule

bind result_buffer rb_chk i_rb_chk (
  .clk(clk), .rst(rst), .conv_vld(conv_vld), .rd_en(rd_en), .cfg_we(cfg_we),
  .wfr_en(wfr_en), .res_evt(res_evt), .rd_vld(rd_vld), .lost(lost)
);

// File: tb/test_result_buffer.sv
module test_result_buffer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv_vld = 0, rd_en = 0, cfg_we = 0, wfr_en = 0;
  logic [2:0] conv_ch = 0, cfg_ch = 0;
  logic [11:0] conv_data = 0;
  logic [3:0] rd_idx = 0, cfg_ptr = 0, cfg_depth = 0;
  logic [1:0] acc_sel = 0, width_sel = 0;
  logic [13:0] rd_data;
  logic rd_vld, res_evt, lost;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  result_buffer i_result_buffer (.*);

  // entry: [31] op (1 read), [30:27] ch/index, [26:15] data, [14:1] expected data, [0] expected valid
  function automatic logic [31:0] vec(input bit op, input int sel, input int d,
                                      input int e, input bit v);
    return {op, 4'(sel), 12'(d), 14'(e), v};
  endfunction

  localparam logic [31:0] VEC [10] = '{
    vec(0, 0, 'hABC, 0, 0),
    vec(1, 0, 0, 'hABC, 1),
    vec(1, 0, 0, 'hABC, 0),
    vec(0, 3, 'h123, 0, 0),
    vec(1, 6, 0, 'h123, 1),
    vec(0, 3, 'h456, 0, 0),
    vec(0, 3, 'h789, 0, 0),
    vec(1, 6, 0, 'h789, 1),
    vec(0, 7, 'hFFF, 0, 0),
    vec(1, 14, 0, 'hFFF, 1)
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic conv(input int ch, input int d);
    conv_vld = 1; conv_ch = 3'(ch); conv_data = 12'(d);
    @(negedge clk);
    conv_vld = 0;
  endtask

  task automatic rd(input int idx);
    rd_en = 1; rd_idx = 4'(idx);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic cfg(input int ch, input int ptr, input int dep);
    cfg_we = 1; cfg_ch = 3'(ch); cfg_ptr = 4'(ptr); cfg_depth = 4'(dep);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_vld", rd_vld, 0);
    chk("R1 res_evt", res_evt, 0);
    chk("R1 lost", lost, 0);

    // R2 R3 R7 vector table, default mapping ch i -> reg 2i
    foreach (VEC[n]) begin
      if (VEC[n][31]) begin
        rd(int'(VEC[n][30:27]));
        chk("R2 data", rd_data, int'(VEC[n][14:1]));
        chk("R2 valid", rd_vld, int'(VEC[n][0]));
      end else begin
        conv(int'(VEC[n][30:27]), int'(VEC[n][26:15]));
        chk("R7 event", res_evt, 1);
      end
    end
    @(negedge clk);
    chk("R7 event one cycle", res_evt, 0);
    chk("R3 no lost when overwriting", lost, 0);

    // R4 read protection
    wfr_en = 1;
    conv(1, 'h111);
    chk("R4 first accepted", res_evt, 1);
    conv(1, 'h222);
    chk("R4 blocked no event", res_evt, 0);
    chk("R4 lost set", lost, 1);
    @(negedge clk);
    chk("R4 lost sticky", lost, 1);
    rd(2);
    chk("R4 old value kept", rd_data, 'h111);
    conv(1, 'h333);
    chk("R4 accepted after read", res_evt, 1);
    rd(2);
    chk("R4 new value", rd_data, 'h333);

    // R5 configuration clears lost
    cfg(1, 2, 0);
    chk("R5 lost cleared", lost, 0);

    // R6 ring of three stages at base 8
    cfg(2, 8, 2);
    conv(2, 10); conv(2, 20); conv(2, 30);
    chk("R6 third stored", res_evt, 1);
    conv(2, 40);
    chk("R6 full ring drops", lost, 1);
    rd(8);  chk("R6 stage0", rd_data, 10);
    rd(9);  chk("R6 stage1", rd_data, 20);
    rd(10); chk("R6 stage2", rd_data, 30);
    conv(2, 50);
    rd(8);  chk("R6 wrap to base, drop did not advance", rd_data, 50);
    chk("R6 valid", rd_vld, 1);
    wfr_en = 0;

    // R9 narrowing
    width_sel = 1;
    conv(0, 'hABC);
    rd(0); chk("R9 10-bit", rd_data, 'h2AF);
    width_sel = 2;
    conv(0, 'hABC);
    rd(0); chk("R9 8-bit", rd_data, 'hAB);
    width_sel = 3;
    conv(0, 'h5F3);
    rd(0); chk("R9 code 3 as 8-bit", rd_data, 'h5F);
    width_sel = 0;

    // R6 address wrap past register 15
    cfg(6, 15, 1);
    conv(6, 'hAA); conv(6, 'hBB);
    rd(15); chk("R6 base 15", rd_data, 'hAA);
    rd(0);  chk("R6 wraps to 0", rd_data, 'hBB);

    // R8 accumulation
    acc_sel = 2;
    conv(5, 100); chk("R8 no event mid-sum", res_evt, 0);
    conv(5, 200); chk("R8 no event mid-sum", res_evt, 0);
    conv(5, 300); chk("R8 event at end", res_evt, 1);
    rd(10); chk("R8 sum of three", rd_data, 600);
    acc_sel = 3;
    for (int k = 0; k < 4; k++) conv(5, 'hFFF);
    rd(10); chk("R8 full-scale sum of four", rd_data, 'h3FFC);
    acc_sel = 0;

    done = 1;
    summary();
  end
endmodule